// File: doc/BRIEF.md
# Power-On Reset Sequencer with Supply Hysteresis

This block produces the chip-wide active-low system reset. Its inputs are two digitized supply comparators and an external active-low reset pin. One comparator says the supply is above an upper threshold. The other says the supply is below a lower threshold, which sits a hysteresis margin under the upper one. All three inputs are asynchronous to the clock. Reset asserts at once, without waiting for a clock, whenever the supply is low or the pin is pulled low. It releases synchronously, and only after a fixed stretch of 65536 clock cycles with every cause absent.

While the supply ramps up, the block keeps reset asserted until the upper comparator has fired, and then waits out the stretch. Once released, the system runs on through the band between the two thresholds. Only a crossing of the lower threshold brings reset back. The pin can force a complete reset at any moment, and its release is followed by the same stretch.

A two-bit cause register records which source produced the last reset. Software clears it with an acknowledge strobe once the cause has gone away.

Top module: `por_sequencer`

## Requirements
- R1: After the below-lower input was last high, `sys_rst_n_o` stays 0 until the above-upper input has been seen high, even while both comparator inputs are 0.
- R2: After `sup_above_i` rises, with the pin high and `sup_below_i` low, `sys_rst_n_o` is still 0 after the 65539th rising clock edge. It is 1 after the 65540th edge: two synchronizer stages, one supply-latch stage, 65536 stretch cycles and one release edge.
- R3: Once `sys_rst_n_o` is 1, it stays 1 while `sup_below_i` is 0 and the pin is high, whatever `sup_above_i` does.
- R4: `sup_below_i` going high drives `sys_rst_n_o` to 0 at once, before any clock edge.
- R5: `ext_rst_n_i` going low drives `sys_rst_n_o` to 0 at once, at any time, including during a running stretch.
- R6: A new reset cause during the stretch discards the cycles already counted. The full count starts again once the cause is gone.
- R7: After `ext_rst_n_i` returns high with the supply already accepted, `sys_rst_n_o` is 0 after the 65538th rising edge and 1 after the 65539th: two synchronizer stages, 65536 stretch cycles and one release edge.
- R8: `cause_o` uses 2'b01 for a supply reset, 2'b10 for a pin reset and 2'b00 for none. It takes the active cause at the first rising edge after that cause appears.
- R9: When a supply cause and a pin cause are both active, `cause_o` shows 2'b01.
- R10: A high `cause_ack_i` sets `cause_o` to 2'b00 at the next edge only when no cause is active. While a cause is active, the acknowledge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| sup_above_i | input | 1 | Asynchronous comparator: supply above the upper threshold |
| sup_below_i | input | 1 | Asynchronous comparator: supply below the lower threshold |
| ext_rst_n_i | input | 1 | Asynchronous external reset pin, active low |
| cause_ack_i | input | 1 | Acknowledge strobe that clears the cause register |
| sys_rst_n_o | output | 1 | System reset, active low, asynchronous assert and synchronous release |
| cause_o | output | 2 | Last reset cause: 00 none, 01 supply, 10 pin |

## Verification
Two pairs of events can land in the same cycle. The first pair is the supply cause and the pin cause. The bench pulls the pin low and, while it is still low, raises the below-lower input. It then expects the supply code to win in the cause register. The second pair is an acknowledge and a reset cause that is still active. The bench strobes the acknowledge while the pin is held low and expects the pin code to survive. The restart rule is provoked by pulsing the pin deep inside a power-up stretch. The release edge is then checked against the full count measured from the end of the pulse.

// File: rtl/por_seq_pkg.sv
`timescale 1ns/1ps
package por_seq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_SUPPLY = 2'b01,
    CAUSE_PIN    = 2'b10
  } cause_e;

  // Cause selection: supply outranks pin, acknowledge only when idle.
  function automatic cause_e pick_cause(input logic supply_ok, input logic pin_ok,
                                        input logic ack, input cause_e cur);
    if (!supply_ok)  return CAUSE_SUPPLY;
    else if (!pin_ok) return CAUSE_PIN;
    else if (ack)     return CAUSE_NONE;
    else              return cur;
  endfunction
endpackage

// File: rtl/por_sync.sv
`timescale 1ns/1ps
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_n_i,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) chain <= '0;
        else          chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) chain <= '0;
        else          chain <= {chain[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[LAST];
endmodule

// File: rtl/por_hyst.sv
`timescale 1ns/1ps
module por_hyst (
  input  logic clk_i,
  input  logic below_i,
  input  logic above_sync_i,
  output logic supply_ok_o
);
  // Set by the synchronized upper comparator, cleared asynchronously by the lower one.
  always_ff @(posedge clk_i or posedge below_i) begin
    if (below_i)           supply_ok_o <= 1'b0;
    else if (above_sync_i) supply_ok_o <= 1'b1;
  end
endmodule

// File: rtl/por_stretch.sv
`timescale 1ns/1ps
module por_stretch
  import por_seq_pkg::*;
#(
  parameter int STRETCH_CYCLES = 65536
) (
  input  logic       clk_i,
  input  logic       kill_i,
  input  logic       go_i,
  output logic       rst_n_o,
  output seq_state_e state_o
);
  localparam int CW = (STRETCH_CYCLES > 1) ? $clog2(STRETCH_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STRETCH_CYCLES - 1);

  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  seq_state_e      st_q, st_nx;
  logic [CW-1:0]   cnt_q, cnt_nx;
  logic            count_done;

  assign count_done = (cnt_q == LAST);

  always_comb begin
    st_nx  = st_q;
    cnt_nx = cnt_q;
    unique case (st_q)
      ST_HOLD: begin
        cnt_nx = '0;
        if (go_i) st_nx = ST_STRETCH;
      end
      ST_STRETCH: begin
        if (!go_i) begin
          st_nx  = ST_HOLD;
          cnt_nx = '0;
        end else if (count_done) begin
          st_nx = ST_RUN;
        end else begin
          cnt_nx = step_count(cnt_q);
        end
      end
      ST_RUN: begin
        if (!go_i) begin
          st_nx  = ST_HOLD;
          cnt_nx = '0;
        end
      end
      default: begin
        st_nx  = ST_HOLD;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or posedge kill_i) begin
    if (kill_i) begin
      st_q    <= ST_HOLD;
      cnt_q   <= '0;
      rst_n_o <= 1'b0;
    end else begin
      st_q    <= st_nx;
      cnt_q   <= cnt_nx;
      rst_n_o <= (st_nx == ST_RUN);
    end
  end

  assign state_o = st_q;

  a_r2_count_advances: assert property (@(posedge clk_i) disable iff (kill_i)
    (st_q == ST_STRETCH && go_i && !count_done) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  a_r2_release_after_full_count: assert property (@(posedge clk_i) disable iff (kill_i)
    $rose(rst_n_o) |-> ($past(cnt_q) == LAST));

  a_r6_restart_from_zero: assert property (@(posedge clk_i) disable iff (kill_i)
    (st_q == ST_STRETCH && !go_i) |=> (st_q == ST_HOLD && cnt_q == '0));

  a_r3_stays_released: assert property (@(posedge clk_i) disable iff (kill_i)
    (rst_n_o && go_i) |=> rst_n_o);
endmodule

// File: rtl/por_sequencer.sv
`timescale 1ns/1ps
module por_sequencer
  import por_seq_pkg::*;
#(
  parameter int STRETCH_CYCLES = 65536,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       sup_above_i,
  input  logic       sup_below_i,
  input  logic       ext_rst_n_i,
  input  logic       cause_ack_i,
  output logic       sys_rst_n_o,
  output logic [1:0] cause_o
);
  logic       kill;        // any asynchronous reset cause
  logic       pin_ok;      // pin high, synchronized, cleared asynchronously
  logic       above_sync;  // upper comparator, synchronized
  logic       supply_ok;   // supply accepted, hysteresis latch
  logic       go;          // all causes absent
  cause_e     cause_q;
  seq_state_e seq_state;

  assign kill = ~ext_rst_n_i | sup_below_i;

  por_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i   (clk_i),
    .clr_n_i (ext_rst_n_i),
    .d_i     (1'b1),
    .q_o     (pin_ok)
  );

  por_sync #(.STAGES(SYNC_STAGES)) u_above_sync (
    .clk_i   (clk_i),
    .clr_n_i (1'b1),
    .d_i     (sup_above_i),
    .q_o     (above_sync)
  );

  por_hyst u_hyst (
    .clk_i        (clk_i),
    .below_i      (sup_below_i),
    .above_sync_i (above_sync),
    .supply_ok_o  (supply_ok)
  );

  assign go = pin_ok & supply_ok;

  por_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk_i   (clk_i),
    .kill_i  (kill),
    .go_i    (go),
    .rst_n_o (sys_rst_n_o),
    .state_o (seq_state)
  );

  always_ff @(posedge clk_i) begin
    cause_q <= pick_cause(supply_ok, pin_ok, cause_ack_i, cause_q);
  end

  assign cause_o = cause_q;

  a_r1_low_until_supply: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
    !supply_ok |-> !sys_rst_n_o);

  a_r5_pin_forces_reset: assert property (@(posedge clk_i) disable iff (sup_below_i)
    !pin_ok |-> !sys_rst_n_o);

  a_r10_ack_clears_when_idle: assert property (@(posedge clk_i) disable iff (kill)
    (cause_ack_i && supply_ok && pin_ok) |=> (cause_o == CAUSE_NONE));

  a_r9_supply_outranks_pin: assert property (@(posedge clk_i) disable iff (ext_rst_n_i)
    (!supply_ok && !pin_ok) |=> (cause_o == CAUSE_SUPPLY));

  a_r3_run_only_when_clear: assert property (@(posedge clk_i) disable iff (kill)
    (seq_state == ST_RUN) |-> go);
endmodule

// File: tb/por_sequencer_bench.sv
`timescale 1ns/1ps
module por_sequencer_bench;
  localparam int N = 65536;

  logic       clk;
  logic       above, below, pin_n, ack;
  logic       rst_n;
  logic [1:0] cause;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 0;

  por_sequencer u_por_sequencer (
    .clk_i       (clk),
    .sup_above_i (above),
    .sup_below_i (below),
    .ext_rst_n_i (pin_n),
    .cause_ack_i (ack),
    .sys_rst_n_o (rst_n),
    .cause_o     (cause)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected release edge counts, restated from the requirements.
  function automatic int pin_release_edges();
    return 2 + N + 1;
  endfunction
  function automatic int supply_release_edges();
    return 2 + 1 + N + 1;
  endfunction

  typedef struct packed {
    logic       hi;
    logic       ackv;
    logic       exp_rst;
    logic [1:0] exp_cause;
  } vec_t;

  // Rows applied after a pin-driven release; cause starts at 2'b10.
  localparam vec_t VEC [5] = '{
    '{hi: 1'b1, ackv: 1'b0, exp_rst: 1'b1, exp_cause: 2'b10},
    '{hi: 1'b0, ackv: 1'b0, exp_rst: 1'b1, exp_cause: 2'b10},
    '{hi: 1'b0, ackv: 1'b1, exp_rst: 1'b1, exp_cause: 2'b00},
    '{hi: 1'b1, ackv: 1'b0, exp_rst: 1'b1, exp_cause: 2'b00},
    '{hi: 1'b0, ackv: 1'b1, exp_rst: 1'b1, exp_cause: 2'b00}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    above = 1'b0; below = 1'b1; pin_n = 1'b1; ack = 1'b0;
    step(20);
    check("R1 held while supply low", rst_n, 0);
    check("R8 supply cause code", cause, 2'b01);

    below = 1'b0;                      // band between thresholds during ramp
    step(10);
    check("R1 held in band before upper crossing", rst_n, 0);

    above = 1'b1;
    step(1000);
    check("R2 still stretching", rst_n, 0);

    pin_n = 1'b0;                      // new cause inside the stretch
    #1;
    check("R5 pin forces reset", rst_n, 0);
    @(negedge clk);
    step(0);
    check("R8 pin cause code", cause, 2'b10);
    ack = 1'b1;
    step(1);
    check("R10 ack ignored while pin active", cause, 2'b10);
    ack = 1'b0;
    step(2);

    pin_n = 1'b1;
    step(pin_release_edges() - 1);
    check("R6 R7 still low one edge before release", rst_n, 0);
    step(1);
    check("R6 R7 released after full pin stretch", rst_n, 1);

    for (int i = 0; i < 5; i++) begin
      above = VEC[i].hi;
      ack   = VEC[i].ackv;
      step(1);
      check("R3 release held across band", rst_n, VEC[i].exp_rst);
      check("R10 cause after vector", cause, VEC[i].exp_cause);
    end
    ack = 1'b0;

    above = 1'b0; below = 1'b1;        // supply drops below lower threshold
    #1;
    check("R4 immediate assert on supply drop", rst_n, 0);
    @(negedge clk);
    step(0);
    check("R8 supply cause after drop", cause, 2'b01);
    below = 1'b0;
    step(5);
    check("R1 held in band after drop", rst_n, 0);
    above = 1'b1;
    step(supply_release_edges() - 1);
    check("R2 low one edge before release", rst_n, 0);
    step(1);
    check("R2 released after full supply stretch", rst_n, 1);

    pin_n = 1'b0;
    #1;
    check("R5 pin forces reset while running", rst_n, 0);
    above = 1'b0; below = 1'b1;
    step(1);
    check("R9 supply outranks pin", cause, 2'b01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(190000 * 8);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule